// File: doc/BRIEF.md
# Recursive systematic convolutional encoder with trellis termination

This block is one rate-1/3 constituent encoder of the kind used in parallel concatenated coding. It holds an eight-state shift register of three delay elements. For every accepted input bit it emits one beat of three bits: a systematic bit and two parity bits. The register feedback follows 1 + D² + D³. The first parity output follows (1 + D + D³)/(1 + D² + D³) and the second follows (1 + D + D² + D³)/(1 + D² + D³). The register starts from the all-zero state.

Input bits arrive on a valid/ready stream and coded beats leave on a second valid/ready stream through a one-entry output register. Back-pressure rules: an input bit is taken only on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high only when the block is enabled, no termination is running or being requested, and the output register is empty or is being emptied in that same cycle. An output beat is held unchanged while `out_valid` is high and `out_ready` is low.

A one-cycle pulse on `term_go` starts trellis termination. The encoder then produces three tail beats by itself. In each tail beat the register input is replaced by the current feedback value, which clears the register to zero. Input is blocked for the whole tail. `en` is a plain control pin. When it is low, the register and the pending beat are frozen, the output pins read zero and no handshake completes.

Top module: `rsc_encoder`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 while `en` is 1, and the first coded bit is computed from the all-zero register state.
- R2: For a data beat (`out_tail` = 0), `out_sys` equals the accepted input bit.
- R3: With s1 the newest register stage, fb = s2 ^ s3 and w = u ^ fb, where u is the register input: the input bit for data, fb during tail. `out_par0` = w ^ s1 ^ s3. The register then shifts w into s1.
- R4: `out_par1` = w ^ s1 ^ s2 ^ s3, using the same w and state as R3.
- R5: A `term_go` pulse that is accepted yields exactly three output beats with `out_tail` = 1. `in_ready` stays 0 from the pulse cycle until the last tail beat has been loaded.
- R6: During tail beats, `out_sys` carries the substituted feedback bit and both parity bits follow R3 and R4. After the third tail beat the register is all zero, so the next data bit is encoded from the zero state.
- R7: While `en` is 0, `out_valid`, `in_ready`, `out_sys`, `out_par0`, `out_par1` and `out_tail` are all 0. The register and any pending beat are kept and resume unchanged when `en` returns to 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, the beat on the output pins stays unchanged in the next enabled cycle and no new input is accepted.
- R9: A bit accepted on a rising edge appears on the output pins with `out_valid` = 1 from that edge on, which gives one cycle of latency.
- R10: `term_go` has no effect while a tail is in progress or while `en` is 0. No extra tail beats are produced in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low freezes state and zeroes outputs |
| term_go | input | 1 | One-cycle request to start the three-beat tail |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Encoder will take the input bit this cycle |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Coded beat present |
| out_ready | input | 1 | Consumer takes the coded beat this cycle |
| out_sys | output | 1 | Systematic bit (feedback bit during tail) |
| out_par0 | output | 1 | First parity bit |
| out_par1 | output | 1 | Second parity bit |
| out_tail | output | 1 | Beat is a termination tail beat |

## Verification
A data beat accepted on a rising edge is on the output pins from that same edge, so the bench expects it at the following falling edge. A `term_go` pulse seen on one edge produces its first tail beat on the next edge, and the other two follow on successive edges whenever the output register has room. The driver pushes each expected beat into a scoreboard queue at the falling edge where its handshake is seen. The monitor pops an entry only at a falling edge where `out_valid` and `out_ready` are both high, so stalls and disabled cycles move no entry. The first falling edge after every acceptance is also checked directly for `out_valid`, and held beats are compared against the previous falling edge.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // One coded output beat.
  typedef struct packed {
    logic tail;
    logic sys;
    logic par0;
    logic par1;
  } rsc_beat_t;

  localparam int unsigned RSC_BEAT_W = $bits(rsc_beat_t);

endpackage

// File: rtl/rsc_core.sv
module rsc_core
  import rsc_pkg::*;
#(
  parameter int unsigned MEM     = 3,
  parameter logic [MEM-1:0] FB_MASK = 3'b110,
  parameter logic [MEM-1:0] P0_MASK = 3'b101,
  parameter logic [MEM-1:0] P1_MASK = 3'b111
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  input  logic           term_sel,
  input  logic           in_bit,
  output rsc_beat_t      beat,
  output logic [MEM-1:0] state
);

  // state[0] is the newest stage s1, state[MEM-1] the oldest.
  logic [MEM-1:0] state_q;
  logic [MEM-1:0] state_d;
  logic           fb_bit;
  logic           reg_in;
  logic           w_bit;

  assign fb_bit = ^(state_q & FB_MASK);
  assign reg_in = term_sel ? fb_bit : in_bit;
  assign w_bit  = reg_in ^ fb_bit;

  always_comb begin
    beat.tail = term_sel;
    beat.sys  = reg_in;
    beat.par0 = w_bit ^ (^(state_q & P0_MASK));
    beat.par1 = w_bit ^ (^(state_q & P1_MASK));
  end

  generate
    if (MEM > 1) begin : g_shift
      assign state_d = {state_q[MEM-2:0], w_bit};
    end else begin : g_single
      assign state_d = w_bit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (advance) begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/rsc_tail_ctl.sv
module rsc_tail_ctl #(
  parameter int unsigned MEM = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic term_go,
  input  logic tail_fire,
  output logic tail_active
);

  localparam int unsigned CW = $clog2(MEM + 1);

  logic [CW-1:0] left_q;

  assign tail_active = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (!tail_active) begin
      if (en && term_go) begin
        left_q <= CW'(MEM);
      end
    end else if (tail_fire) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/rsc_out_reg.sv
module rsc_out_reg
  import rsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      load,
  input  rsc_beat_t beat_in,
  input  logic      out_ready,
  output logic      space,
  output logic      out_valid,
  output rsc_beat_t beat_out
);

  logic      valid_q;
  rsc_beat_t beat_q;
  logic      pop;

  assign pop   = valid_q && out_ready && en;
  assign space = !valid_q || pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      beat_q  <= beat_in;
    end else if (pop) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = en && valid_q;
  assign beat_out  = en ? beat_q : '0;

endmodule

// File: rtl/rsc_encoder.sv
module rsc_encoder
  import rsc_pkg::*;
#(
  parameter int unsigned MEM     = 3,
  parameter logic [MEM-1:0] FB_MASK = 3'b110,
  parameter logic [MEM-1:0] P0_MASK = 3'b101,
  parameter logic [MEM-1:0] P1_MASK = 3'b111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic term_go,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_sys,
  output logic out_par0,
  output logic out_par1,
  output logic out_tail
);

  logic           tail_active;
  logic           tail_fire;
  logic           data_fire;
  logic           space;
  logic           advance;
  logic [MEM-1:0] enc_state;
  rsc_beat_t      beat_c;
  rsc_beat_t      beat_o;

  assign in_ready  = en && !tail_active && !term_go && space;
  assign data_fire = in_valid && in_ready;
  assign tail_fire = tail_active && en && space;
  assign advance   = data_fire || tail_fire;

  rsc_tail_ctl #(.MEM(MEM)) u_tail (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .term_go     (term_go),
    .tail_fire   (tail_fire),
    .tail_active (tail_active)
  );

  rsc_core #(
    .MEM     (MEM),
    .FB_MASK (FB_MASK),
    .P0_MASK (P0_MASK),
    .P1_MASK (P1_MASK)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .term_sel (tail_active),
    .in_bit   (in_bit),
    .beat     (beat_c),
    .state    (enc_state)
  );

  rsc_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load      (advance),
    .beat_in   (beat_c),
    .out_ready (out_ready),
    .space     (space),
    .out_valid (out_valid),
    .beat_out  (beat_o)
  );

  assign out_sys  = beat_o.sys;
  assign out_par0 = beat_o.par0;
  assign out_par1 = beat_o.par1;
  assign out_tail = beat_o.tail;

endmodule

// File: rtl/rsc_encoder_chk.sv
module rsc_encoder_chk #(
  parameter int unsigned MEM = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_sys,
  input logic           out_par0,
  input logic           out_par1,
  input logic           out_tail,
  input logic           tail_active,
  input logic [MEM-1:0] state
);

  localparam int unsigned CW = $clog2(MEM + 2);

  logic [CW-1:0] tail_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_seen <= '0;
    end else if (out_valid && out_ready) begin
      tail_seen <= out_tail ? tail_seen + 1'b1 : '0;
    end
  end

  // R7: disabled block shows nothing and accepts nothing
  p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!out_valid && !in_ready && !out_sys && !out_par0 && !out_par1 && !out_tail));

  // R8: stalled beat stays put
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!en || (out_valid &&
      $stable({out_sys, out_par0, out_par1, out_tail}))));

  // R8: no intake while stalled
  p_no_intake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: accepted bit visible next cycle
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid || !en));

  // R5: input blocked during tail
  p_block_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tail_active |-> !in_ready);

  // R5: at most MEM consecutive tail beats leave
  p_tail_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tail_seen <= CW'(MEM));

  // R6: register is clear once the tail ends
  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tail_active) |-> (state == '0));

endmodule

bind rsc_encoder rsc_encoder_chk #(.MEM(MEM)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_sys     (out_sys),
  .out_par0    (out_par0),
  .out_par1    (out_par1),
  .out_tail    (out_tail),
  .tail_active (tail_active),
  .state       (enc_state)
);

// File: tb/tb_rsc_encoder.sv
module tb_rsc_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic term_go = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_sys, out_par0, out_par1, out_tail;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit stall_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] dlfsr = 16'h1D2B;

  // expected beat: {tail, sys, par0, par1}
  logic [3:0] exp_q[$];
  logic [2:0] ms = 3'b000; // model register, bit0 newest

  always #(CLK_PERIOD/2) clk = ~clk;

  rsc_encoder dut (
    .clk(clk), .rst_n(rst_n), .en(en), .term_go(term_go),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sys(out_sys), .out_par0(out_par0), .out_par1(out_par1),
    .out_tail(out_tail)
  );

  function automatic logic [3:0] model_step(input logic u, input logic tl);
    logic f, x, w, a, b;
    f = ms[1] ^ ms[2];
    x = tl ? f : u;
    w = x ^ f;
    a = w ^ ms[0] ^ ms[2];
    b = w ^ ms[0] ^ ms[1] ^ ms[2];
    ms = {ms[1], ms[0], w};
    return {tl, x, a, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // out_ready driver
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_on ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic       prev_hold = 1'b0;
  logic [3:0] prev_got = '0;
  always @(negedge clk) begin
    logic [3:0] got;
    got = {out_tail, out_sys, out_par0, out_par1};
    if (rst_n) begin
      if (prev_hold && en)
        check(out_valid && (got == prev_got), "R8 held beat", got, prev_got);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 R10 unexpected beat", got, 4'bxxxx);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(got == e, "R2 R3 R4 R6 beat", got, e);
        end
      end
      if (en) begin
        prev_hold = out_valid && !out_ready;
        prev_got  = got;
      end
    end
  end

  task automatic send_bit(input logic b);
    bit taken;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_bit   = b;
    taken    = 1'b0;
    while (!taken) begin
      @(negedge clk);
      if (in_ready) begin
        exp_q.push_back(model_step(b, 1'b0));
        taken = 1'b1;
      end else begin
        @(posedge clk); #1;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, "R9 latency", {3'b0, out_valid}, 4'b0001);
  endtask

  task automatic do_tail(input bit dup);
    @(posedge clk); #1;
    term_go = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R5 ready low on request", {3'b0, in_ready}, 4'b0000);
    @(posedge clk); #1;
    term_go = dup; // R10: repeat request while tail runs
    for (int i = 0; i < 3; i++) exp_q.push_back(model_step(1'b0, 1'b1));
    @(negedge clk);
    check(in_ready == 1'b0, "R5 ready low in tail", {3'b0, in_ready}, 4'b0000);
    @(posedge clk); #1;
    term_go = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 queue drained", 4'(exp_q.size()), 4'b0000);
  endtask

  task automatic rand_bits(input int n);
    for (int i = 0; i < n; i++) begin
      dlfsr = {dlfsr[14:0], dlfsr[15] ^ dlfsr[14] ^ dlfsr[12] ^ dlfsr[3]};
      send_bit(dlfsr[0]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog expired", 4'b0, 4'b0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", {3'b0, out_valid}, 4'b0000);
    check(in_ready == 1'b1, "R1 in_ready after reset", {3'b0, in_ready}, 4'b0001);

    // R1 R2 R3 R4: first bits from zero state, impulse
    send_bit(1'b1);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    // all-ones and alternating patterns
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    for (int i = 0; i < 8; i++) send_bit(i[0]);
    rand_bits(20);
    // R5 R6: terminate, then zero-state encoding
    do_tail(1'b0);
    send_bit(1'b0);
    send_bit(1'b1);
    rand_bits(10);
    drain();

    // R8: random back-pressure
    stall_on = 1'b1;
    rand_bits(30);
    do_tail(1'b0);
    rand_bits(12);
    // R10: duplicate request during tail
    do_tail(1'b1);
    rand_bits(8);
    stall_on = 1'b0;
    drain();

    // R7: enable low with a beat pending
    stall_on = 1'b1;
    send_bit(1'b1);
    @(posedge clk); #1;
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check({out_valid, in_ready, out_sys, out_par0, out_par1, out_tail} == 6'b0,
            "R7 outputs gated", {out_sys, out_par0, out_par1, out_tail}, 4'b0000);
    end
    // R10: request while disabled has no effect
    @(posedge clk); #1;
    term_go = 1'b1;
    @(posedge clk); #1;
    term_go = 1'b0;
    en = 1'b1;
    stall_on = 1'b0;
    rand_bits(10);
    drain();

    // R6: full tail from random state, then impulse again
    rand_bits(7);
    do_tail(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b0);
    drain();

    finish_run();
  end

endmodule